// File: doc/BRIEF.md
# Processor Run/Stop Power Controller

This block starts and halts a group of virtual processors (VPs) inside a cluster. It sits on a simple register bus with an address, 64-bit write data, 64-bit read data, a write strobe and a read strobe. Software starts VPs by writing a bitmask to the run register. It halts VPs by writing a bitmask to the stop register. It reads the status register to see which VPs are running.

A VP that is started gets a one-cycle reset pulse on its own line, and its running bit is set on the following cycle. A VP that is halted gets a one-cycle halt request, and its running bit clears at the same clock edge. Each register can be reached through two address windows that behave the same. After reset, a parameter-selected set of VPs is started through the normal start path, so those VPs also get reset pulses.

Top module: `vp_runstop_ctl`

## Requirements
- R1: Run and stop data bits at positions NUM_VP and above have no effect. Only the low NUM_VP bits of the written value are used.
- R2: A bus write to the run register raises `vp_reset` for one cycle on every VP whose written bit is 1 and that is neither running nor already receiving a start pulse. The pulse appears in the cycle after the write edge.
- R3: The running bit of a started VP becomes 1 one clock after its reset pulse. A status read in the pulse cycle still returns the old mask.
- R4: A bus write to the stop register raises `vp_halt` for one cycle on every VP whose written bit is 1 and that is running. Its running bit clears at the same edge. Requested VPs that are not running get no halt request.
- R5: A read of the status register returns the running mask in bits [NUM_VP-1:0]. Bits NUM_VP and above read as zero.
- R6: The address offsets are fixed: stop at 0x20, run at 0x28 and status at 0x30. Each appears in two windows, at base 0x000 and base 0x100, and both windows behave the same. Any address bits above bit 8 must be zero.
- R7: During reset, the running mask, `vp_reset`, `vp_halt` and `rdata` are all zero. In the first cycle after reset is released, the START_RUNNING set is started through the run path: the reset pulses appear in the next cycle, and the running bits are set one cycle after that. A START_RUNNING value larger than the valid mask stops elaboration.
- R8: Writes to any other address change nothing. Reads of any other address, including the stop and run offsets, return zero. `rdata` is zero whenever `rd_en` is low.
- R9: A stop write that arrives while a VP's start pulse is still active does not touch that VP. The VP still becomes running, and the reset and halt lines are never high for the same VP together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 64 | Combinational read data |
| vp_reset | output | NUM_VP | One-cycle start/reset pulse for each VP |
| vp_halt | output | NUM_VP | One-cycle halt request for each VP |

## Verification
The bench builds the block with NUM_VP = 4, START_RUNNING = 0x5 and ADDR_W = 12. Four VPs keep the state space small, so every 8-bit write value can be swept as a run write and then as a stop write through both windows. The upper four bits of each value exercise the masking. The non-zero boot set makes the reset start path visible. The 12-bit address lets the bench try addresses above the two windows, which must decode as unknown.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam logic [7:0]  OFS_STOP = 8'h20;
  localparam logic [7:0]  OFS_RUN  = 8'h28;
  localparam logic [7:0]  OFS_STAT = 8'h30;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RUN,
    SEL_STOP,
    SEL_STAT
  } sel_e;

  // mask of the VPs that exist
  function automatic logic [DATA_W-1:0] vp_mask(input int unsigned n);
    if (n >= DATA_W) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // VPs a run request may start: requested, present, idle, not pending
  function automatic logic [DATA_W-1:0] start_set(
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] req,
    input logic [DATA_W-1:0] running,
    input logic [DATA_W-1:0] pending
  );
    return req & mask & ~(running | pending);
  endfunction

  // VPs a stop request may halt: requested, present, running
  function automatic logic [DATA_W-1:0] stop_set(
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] req,
    input logic [DATA_W-1:0] running
  );
    return req & mask & running;
  endfunction
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
  import vpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              run_wr,
  output logic              stop_wr,
  output logic              stat_rd
);
  sel_e sel;
  logic upper_zero;

  // bit 8 selects the window; every higher bit must be clear
  assign upper_zero = ((addr >> 9) == '0);

  always_comb begin
    sel = SEL_NONE;
    if (upper_zero) begin
      unique case (addr[7:0])
        OFS_RUN:  sel = SEL_RUN;
        OFS_STOP: sel = SEL_STOP;
        OFS_STAT: sel = SEL_STAT;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  assign run_wr  = wr_en && (sel == SEL_RUN);
  assign stop_wr = wr_en && (sel == SEL_STOP);
  assign stat_rd = rd_en && (sel == SEL_STAT);
endmodule

// File: rtl/vpc_run_core.sv
module vpc_run_core
  import vpc_pkg::*;
#(
  parameter int unsigned       NUM_VP        = 1,
  parameter logic [DATA_W-1:0] START_RUNNING = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_wr,
  input  logic              stop_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] running,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt
);
  localparam logic [DATA_W-1:0] MASK = vp_mask(NUM_VP);

  logic [NUM_VP-1:0] run_q, rst_q, halt_q;
  logic              boot_q;
  logic [DATA_W-1:0] run64, rst64, req_run, start64, stop64;
  logic [NUM_VP-1:0] start_now, stop_now;

  always_comb begin
    run64 = '0;
    rst64 = '0;
    run64[NUM_VP-1:0] = run_q;
    rst64[NUM_VP-1:0] = rst_q;
  end

  // the boot set enters through the same path as a bus run write
  assign req_run   = (boot_q ? START_RUNNING : '0) | (run_wr ? wdata : '0);
  assign start64   = start_set(MASK, req_run, run64, rst64);
  assign stop64    = stop_wr ? stop_set(MASK, wdata, run64) : '0;
  assign start_now = start64[NUM_VP-1:0];
  assign stop_now  = stop64[NUM_VP-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      rst_q  <= '0;
      halt_q <= '0;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      rst_q  <= start_now;
      halt_q <= stop_now;
      run_q  <= (run_q & ~stop_now) | rst_q;
    end
  end

  assign running  = run64;
  assign vp_reset = rst_q;
  assign vp_halt  = halt_q;

  // R2
  reset_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q != '0) |=> ((rst_q & $past(rst_q)) == '0));
  // R2
  reset_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_q & run_q) == '0));
  // R3
  run_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q != '0) |=> ((run_q & $past(rst_q)) == $past(rst_q)));
  // R4
  halt_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q != '0) |-> ((halt_q & run_q) == '0));
  // R4
  halt_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q != '0) |-> (($past(run_q) & halt_q) == halt_q));
  // R9
  reset_halt_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_q & halt_q) == '0));
endmodule

// File: rtl/vp_runstop_ctl.sv
module vp_runstop_ctl
  import vpc_pkg::*;
#(
  parameter int unsigned       NUM_VP        = 1,
  parameter logic [DATA_W-1:0] START_RUNNING = 64'h1,
  parameter int unsigned       ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [63:0]       rdata,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt
);
  localparam logic [DATA_W-1:0] MASK = vp_mask(NUM_VP);

  // R7: the boot set must name existing VPs only
  if (START_RUNNING > MASK) begin : g_bad_start
    $error("START_RUNNING exceeds the valid VP mask");
  end
  if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_count
    $error("NUM_VP must lie in 1..64");
  end
  if (ADDR_W < 9) begin : g_bad_addr
    $error("ADDR_W must cover both windows");
  end

  logic              run_wr, stop_wr, stat_rd;
  logic [DATA_W-1:0] running;

  vpc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .run_wr  (run_wr),
    .stop_wr (stop_wr),
    .stat_rd (stat_rd)
  );

  vpc_run_core #(.NUM_VP(NUM_VP), .START_RUNNING(START_RUNNING)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_wr   (run_wr),
    .stop_wr  (stop_wr),
    .wdata    (wdata),
    .running  (running),
    .vp_reset (vp_reset),
    .vp_halt  (vp_halt)
  );

  assign rdata = stat_rd ? running : '0;

  // R5
  rdata_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~MASK) == '0));
  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_wr, stop_wr}));
endmodule

// File: tb/vp_runstop_ctl_tb.sv
`timescale 1ns/1ps
module vp_runstop_ctl_tb;
  localparam int unsigned NV = 4;
  localparam logic [63:0] BOOT = 64'h5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [63:0] rdata;
  logic [NV-1:0] vp_reset, vp_halt;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_run;

  always #4 clk = ~clk;

  vp_runstop_ctl #(.NUM_VP(NV), .START_RUNNING(BOOT), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .vp_reset(vp_reset), .vp_halt(vp_halt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit win, input logic [63:0] v);
    logic [11:0] base;
    logic [3:0]  pulse;
    base  = win ? 12'h100 : 12'h000;
    pulse = v[3:0] & ~exp_run;
    @(negedge clk);
    addr = base + 12'h028; wdata = v; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; addr = base + 12'h030; rd_en = 1'b1;
    #1;
    chk("R2 run pulse", 64'(vp_reset), 64'(pulse));
    chk("R3 old status in pulse cycle", rdata, 64'(exp_run));
    exp_run = exp_run | pulse;
    @(negedge clk);
    #1;
    chk("R2 pulse ends", 64'(vp_reset), 64'h0);
    chk("R5 R6 status after run", rdata, 64'(exp_run));
    rd_en = 1'b0;
  endtask

  task automatic stop_op(input bit win, input logic [63:0] v);
    logic [11:0] base;
    logic [3:0]  hreq;
    base = win ? 12'h100 : 12'h000;
    hreq = v[3:0] & exp_run;
    @(negedge clk);
    addr = base + 12'h020; wdata = v; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; addr = base + 12'h030; rd_en = 1'b1;
    exp_run = exp_run & ~hreq;
    #1;
    chk("R4 halt request", 64'(vp_halt), 64'(hreq));
    chk("R4 running cleared", rdata, 64'(exp_run));
    chk("R1 no stray reset", 64'(vp_reset), 64'h0);
    @(negedge clk);
    #1;
    chk("R4 halt ends", 64'(vp_halt), 64'h0);
    rd_en = 1'b0;
  endtask

  task automatic read_at(input logic [11:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    chk(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_run = '0;
    repeat (3) @(negedge clk);
    addr = 12'h030; rd_en = 1'b1;
    #1;
    chk("R7 reset rdata", rdata, 64'h0);
    chk("R7 reset pulses", 64'(vp_reset), 64'h0);
    chk("R7 reset halts", 64'(vp_halt), 64'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R7 boot pulse", 64'(vp_reset), BOOT);
    chk("R7 boot status old", rdata, 64'h0);
    @(negedge clk); #1;
    chk("R7 boot running", rdata, BOOT);
    chk("R7 boot pulse ends", 64'(vp_reset), 64'h0);
    rd_en = 1'b0;
    exp_run = BOOT[3:0];

    // R1 R2 R4 R6: sweep every 8-bit value through both windows
    for (int w = 0; w < 2; w++) begin
      for (int v = 0; v < 256; v++) begin
        run_op(w[0], 64'(v));
        stop_op(w[0], 64'(v ^ 8'h5A));
      end
    end

    // R1: high bits alone do nothing
    stop_op(1'b0, 64'hF);
    run_op(1'b0, 64'hFFFF_FFFF_FFFF_FFF0);
    run_op(1'b1, 64'h8000_0000_0000_0003);
    stop_op(1'b1, 64'hF000_0000_0000_0000);

    // R2: repeated run while the pulse is active gives no second pulse
    stop_op(1'b0, 64'hF);
    @(negedge clk);
    addr = 12'h028; wdata = 64'h2; wr_en = 1'b1;
    @(negedge clk); #1;
    chk("R2 first pulse", 64'(vp_reset), 64'h2);
    @(negedge clk); #1;
    wr_en = 1'b0;
    chk("R2 no repeat pulse", 64'(vp_reset), 64'h0);
    exp_run = 4'h2;
    read_at(12'h130, 64'h2, "R2 status after repeat");

    // R9: stop during the pending pulse leaves the VP to start
    @(negedge clk);
    addr = 12'h028; wdata = 64'h1; wr_en = 1'b1;
    @(negedge clk);
    addr = 12'h020; wdata = 64'h1;
    #1;
    chk("R9 pulse present", 64'(vp_reset), 64'h1);
    @(negedge clk); #1;
    wr_en = 1'b0;
    chk("R9 no halt on pending", 64'(vp_halt), 64'h0);
    exp_run = 4'h3;
    read_at(12'h030, 64'h3, "R9 pending VP runs");

    // R8: unknown addresses
    @(negedge clk);
    addr = 12'h048; wdata = '1; wr_en = 1'b1;
    @(negedge clk);
    addr = 12'h228;
    @(negedge clk);
    addr = 12'h220;
    @(negedge clk); #1;
    wr_en = 1'b0;
    chk("R8 no pulse", 64'(vp_reset), 64'h0);
    chk("R8 no halt", 64'(vp_halt), 64'h0);
    read_at(12'h030, 64'h3, "R8 status unchanged");
    read_at(12'h048, 64'h0, "R8 unknown read");
    read_at(12'h028, 64'h0, "R8 run not readable");
    read_at(12'h120, 64'h0, "R8 stop not readable");
    read_at(12'h230, 64'h0, "R8 high address read");
    @(negedge clk);
    addr = 12'h030; rd_en = 1'b0;
    #1;
    chk("R8 no strobe", rdata, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule